// File: doc/BRIEF.md
# External Bus Arbiter with Paired DMA Transfers

This block decides, one bus cycle at a time, which requester owns a shared external bus. Six requester classes compete. Three are urgent: memory refresh, a second DMA engine that sits outside the chip, and an external bus-hold request. Below them come a multi-channel on-chip DMA controller, then a data-transfer controller (DTC), then the CPU. Every request is a level handshake. The requester raises its line and keeps it up until it sees its grant bit. The arbiter grants one cycle for that request, and the requester drops the line during the granted cycle.

The on-chip DMA moves data in read/write pairs. The arbiter selects a pending channel, runs its read cycle, and runs the matching write in the next cycle. No other owner can get between the two. After every write the DMA gives up the bus for at least one cycle, so an urgent request raised in the middle of a burst is served at the next pair boundary. A channel flagged as internal-space does not need the external bus. Its pair runs while an urgent requester owns the external bus in the same cycles.

The DTC and the CPU are held off while any DMA channel has a request waiting or a pair is in flight. The arbiter reports the owner of each cycle as a one-hot grant vector and as a 3-bit cycle-type code. It also reports the DMA phase, channel and space of the current cycle.

Top module: `extbus_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every grant bit is 0, cycle type is 0 (idle) and DMA phase is 0.
- R2: Grants are registered. A request sampled at a clock edge can be granted in the cycle that starts at that edge. A granted request is served once and is not granted again in the next cycle. Grant bits are at most one-hot, with bit 0 refresh, bit 1 external DMA engine, bit 2 bus hold, bit 3 on-chip DMA, bit 4 DTC and bit 5 CPU.
- R3: Fixed priority, from highest: refresh, external DMA engine, bus hold, on-chip DMA, DTC, CPU. Cycle type codes: 0 idle, 1 refresh, 2 external DMA engine, 3 bus hold, 4 DMA read, 5 DMA write, 6 DTC, 7 CPU.
- R4: An external-space DMA read cycle (type 4) is always followed in the next cycle by the write cycle (type 5) of the same channel. No other owner is granted between them.
- R5: The cycle after a DMA write is never a DMA read. A refresh raised during a DMA read is granted exactly two cycles later, in the cycle right after the write.
- R6: The DTC (bit 4) and the CPU (bit 5) are never granted while any DMA channel request is waiting or a DMA read/write pair is in progress.
- R7: DMA requests are one-cycle strobes per channel. They are held until that channel is selected. When several channels are waiting, the lowest index is served first, with one read/write pair per selection.
- R8: A channel whose internal flag is 1 runs its pair without an external grant. An urgent requester may own the external bus in the same cycles. dma_int_o is then 1, and the cycle type never shows 4 or 5.
- R9: DMA phase output: 0 none, 1 read, 2 write. When the phase is 0, dma_ch_o and dma_int_o are 0.
- R10: An external-space DMA selection waits while any urgent request is pending, and starts only once none remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| refresh_req_i | input | 1 | Refresh request (level, held until granted) |
| xdma_req_i | input | 1 | External DMA engine request |
| hold_req_i | input | 1 | External bus-hold request |
| dma_req_i | input | NCH | Per-channel on-chip DMA request strobes |
| dma_int_i | input | NCH | Per-channel flag: transfer targets internal space |
| dtc_req_i | input | 1 | Data-transfer controller request |
| cpu_req_i | input | 1 | CPU request |
| gnt_o | output | 6 | One-hot grant of the current external cycle |
| cyc_type_o | output | 3 | Cycle-type code of the current external cycle |
| dma_cyc_o | output | 2 | DMA phase of the current cycle |
| dma_ch_o | output | CHW | Channel of the current DMA cycle |
| dma_int_o | output | 1 | Current DMA cycle is internal-space |

## Verification
The bench raises a refresh in the read cycle of a running burst and expects it exactly in the slot after the write. A design that split pairs would grant it between read and write. A design that skipped the release slot would starve it. It strobes three channels together and expects them in index order with a gap after each write. It also queues the DTC and the CPU behind DMA requests, including a DMA held back by an urgent request. A design that checked only the DMA state, and not the waiting requests, would let the CPU in early. Finally, an internal-space channel runs alongside refresh and external-engine cycles. A design that made it wait for the bus would shift every record by a cycle.

// File: rtl/extbus_arb_pkg.sv
package extbus_arb_pkg;

    localparam int NSRC     = 6;
    localparam int NURGENT  = 3;
    localparam int SRC_REF  = 0;
    localparam int SRC_XDMA = 1;
    localparam int SRC_HOLD = 2;
    localparam int SRC_DMA  = 3;
    localparam int SRC_DTC  = 4;
    localparam int SRC_CPU  = 5;

    typedef enum logic [2:0] {
        CY_IDLE    = 3'd0,
        CY_REFRESH = 3'd1,
        CY_XDMA    = 3'd2,
        CY_HOLD    = 3'd3,
        CY_DMA_RD  = 3'd4,
        CY_DMA_WR  = 3'd5,
        CY_DTC     = 3'd6,
        CY_CPU     = 3'd7
    } cyc_e;

    typedef enum logic [1:0] {
        DP_NONE  = 2'd0,
        DP_READ  = 2'd1,
        DP_WRITE = 2'd2
    } dphase_e;

endpackage

// File: rtl/extbus_pick_low.sv
module extbus_pick_low #(
    parameter  int N  = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec_i,
    output logic          hit_o,
    output logic [N-1:0]  oh_o,
    output logic [IW-1:0] idx_o
);

    logic [N:0] seen;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_chain
        assign oh_o[g]     = vec_i[g] & ~seen[g];
        assign seen[g + 1] = seen[g] | vec_i[g];
    end

    assign hit_o = seen[N];

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (oh_o[i]) begin
                idx_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/extbus_dma_seq.sv
module extbus_dma_seq
    import extbus_arb_pkg::*;
#(
    parameter  int NCH = 3,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [NCH-1:0] req_i,
    input  logic [NCH-1:0] int_i,
    input  logic           urgent_wait_i,
    output logic           own_nxt_o,
    output logic           wr_nxt_o,
    output logic           hold_low_o,
    output dphase_e        phase_o,
    output logic [CHW-1:0] ch_o,
    output logic           int_o
);

    typedef struct packed {
        dphase_e        ph;
        logic [CHW-1:0] ch;
        logic           intr;
        logic [NCH-1:0] pend;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [NCH-1:0] pend_all;
    logic [NCH-1:0] sel_oh;
    logic [CHW-1:0] sel_idx;
    logic           sel_hit;
    logic           sel_int;

    assign pend_all = seq_q.pend | req_i;
    assign sel_int  = |(int_i & sel_oh);

    extbus_pick_low #(.N(NCH)) u_pick (
        .vec_i (pend_all),
        .hit_o (sel_hit),
        .oh_o  (sel_oh),
        .idx_o (sel_idx)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.pend = pend_all;
        unique case (seq_q.ph)
            DP_READ: begin
                seq_d.ph = DP_WRITE;
            end
            DP_WRITE: begin
                seq_d.ph   = DP_NONE;
                seq_d.ch   = '0;
                seq_d.intr = 1'b0;
            end
            default: begin
                if (sel_hit && (sel_int || !urgent_wait_i)) begin
                    seq_d.ph   = DP_READ;
                    seq_d.ch   = sel_idx;
                    seq_d.intr = sel_int;
                    seq_d.pend = pend_all & ~sel_oh;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seq_q <= '{ph: DP_NONE, ch: '0, intr: 1'b0, pend: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign own_nxt_o  = (seq_d.ph != DP_NONE) && !seq_d.intr;
    assign wr_nxt_o   = (seq_d.ph == DP_WRITE);
    assign hold_low_o = (|seq_d.pend) || (seq_d.ph != DP_NONE);
    assign phase_o    = seq_q.ph;
    assign ch_o       = seq_q.ch;
    assign int_o      = seq_q.intr;

endmodule

// File: rtl/extbus_grant.sv
module extbus_grant
    import extbus_arb_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NURGENT-1:0] urgent_i,
    input  logic               dtc_i,
    input  logic               cpu_i,
    input  logic               dma_own_i,
    input  logic               dma_wr_i,
    input  logic               hold_low_i,
    output logic [NSRC-1:0]    gnt_o,
    output cyc_e               type_o
);

    typedef struct packed {
        logic [NSRC-1:0] gnt;
        cyc_e            ty;
    } own_t;

    own_t own_d, own_q;

    logic               urg_hit;
    logic [NURGENT-1:0] urg_oh;
    logic [1:0]         urg_idx;

    extbus_pick_low #(.N(NURGENT)) u_urgent (
        .vec_i (urgent_i),
        .hit_o (urg_hit),
        .oh_o  (urg_oh),
        .idx_o (urg_idx)
    );

    always_comb begin
        own_d.gnt = '0;
        own_d.ty  = CY_IDLE;
        if (dma_own_i) begin
            own_d.gnt[SRC_DMA] = 1'b1;
            own_d.ty           = dma_wr_i ? CY_DMA_WR : CY_DMA_RD;
        end else if (urg_hit) begin
            own_d.gnt[NURGENT-1:0] = urg_oh;
            own_d.ty               = cyc_e'({1'b0, urg_idx} + 3'd1);
        end else if (!hold_low_i && dtc_i) begin
            own_d.gnt[SRC_DTC] = 1'b1;
            own_d.ty           = CY_DTC;
        end else if (!hold_low_i && cpu_i) begin
            own_d.gnt[SRC_CPU] = 1'b1;
            own_d.ty           = CY_CPU;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            own_q <= '{gnt: '0, ty: CY_IDLE};
        end else begin
            own_q <= own_d;
        end
    end

    assign gnt_o  = own_q.gnt;
    assign type_o = own_q.ty;

endmodule

// File: rtl/extbus_arbiter.sv
module extbus_arbiter
    import extbus_arb_pkg::*;
#(
    parameter  int NCH = 3,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           refresh_req_i,
    input  logic           xdma_req_i,
    input  logic           hold_req_i,
    input  logic [NCH-1:0] dma_req_i,
    input  logic [NCH-1:0] dma_int_i,
    input  logic           dtc_req_i,
    input  logic           cpu_req_i,
    output logic [5:0]     gnt_o,
    output logic [2:0]     cyc_type_o,
    output logic [1:0]     dma_cyc_o,
    output logic [CHW-1:0] dma_ch_o,
    output logic           dma_int_o
);

    logic [NSRC-1:0]    gnt_q;
    cyc_e               type_q;
    logic [NURGENT-1:0] urgent_live;
    logic               dtc_live;
    logic               cpu_live;
    logic               dma_own_nxt;
    logic               dma_wr_nxt;
    logic               dma_hold_low;
    dphase_e            dma_phase;

    // a request granted in the current cycle is considered consumed
    assign urgent_live = {hold_req_i, xdma_req_i, refresh_req_i} & ~gnt_q[SRC_HOLD:SRC_REF];
    assign dtc_live    = dtc_req_i & ~gnt_q[SRC_DTC];
    assign cpu_live    = cpu_req_i & ~gnt_q[SRC_CPU];

    extbus_dma_seq #(.NCH(NCH)) u_seq (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .req_i         (dma_req_i),
        .int_i         (dma_int_i),
        .urgent_wait_i (|urgent_live),
        .own_nxt_o     (dma_own_nxt),
        .wr_nxt_o      (dma_wr_nxt),
        .hold_low_o    (dma_hold_low),
        .phase_o       (dma_phase),
        .ch_o          (dma_ch_o),
        .int_o         (dma_int_o)
    );

    extbus_grant u_grant (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .urgent_i   (urgent_live),
        .dtc_i      (dtc_live),
        .cpu_i      (cpu_live),
        .dma_own_i  (dma_own_nxt),
        .dma_wr_i   (dma_wr_nxt),
        .hold_low_i (dma_hold_low),
        .gnt_o      (gnt_q),
        .type_o     (type_q)
    );

    assign gnt_o      = gnt_q;
    assign cyc_type_o = type_q;
    assign dma_cyc_o  = dma_phase;

endmodule

// File: rtl/extbus_arbiter_chk.sv
module extbus_arbiter_chk #(
    parameter  int NCH = 3,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic           refresh_req_i,
    input logic [5:0]     gnt_o,
    input logic [2:0]     cyc_type_o,
    input logic [1:0]     dma_cyc_o,
    input logic [CHW-1:0] dma_ch_o,
    input logic           dma_int_o
);

    p_onehot_gnt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(gnt_o));

    p_refresh_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (refresh_req_i && !gnt_o[0] && dma_cyc_o != 2'd1) |=> gnt_o[0]);

    p_pair_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dma_cyc_o == 2'd1) |=> (dma_cyc_o == 2'd2) && $stable(dma_ch_o) && $stable(dma_int_o));

    p_ext_pair_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc_type_o == 3'd4) |=> (cyc_type_o == 3'd5));

    p_release_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dma_cyc_o == 2'd2) |=> (dma_cyc_o != 2'd1));

    p_low_blocked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dma_cyc_o != 2'd0) |-> (!gnt_o[4] && !gnt_o[5]));

    p_internal_off_bus_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dma_int_o |-> (cyc_type_o != 3'd4 && cyc_type_o != 3'd5));

    p_idle_fields_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dma_cyc_o == 2'd0) |-> (dma_ch_o == '0 && !dma_int_o));

endmodule

bind extbus_arbiter extbus_arbiter_chk #(.NCH(NCH)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .refresh_req_i (refresh_req_i),
    .gnt_o         (gnt_o),
    .cyc_type_o    (cyc_type_o),
    .dma_cyc_o     (dma_cyc_o),
    .dma_ch_o      (dma_ch_o),
    .dma_int_o     (dma_int_o)
);

// File: tb/extbus_arbiter_tb.sv
`timescale 1ns/1ps
module extbus_arbiter_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] dma_req;
    logic [2:0] dma_int;
    logic [5:0] gnt;
    logic [2:0] cyc_type;
    logic [1:0] dma_cyc;
    logic [1:0] dma_ch;
    logic       dma_in;

    // requester index: 0 refresh, 1 ext DMA engine, 2 hold, 3 DTC, 4 CPU
    int ask [5] = '{default: 0};
    int got [5] = '{default: 0};
    localparam int GBIT [5] = '{0, 1, 2, 4, 5};

    int         n_cmp = 0;
    int         n_bad = 0;
    bit         mon_on = 1'b0;
    logic [2:0] bench_pend = '0;
    logic [7:0] prev_rec = '0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    extbus_arbiter #(.NCH(3)) u_dut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .refresh_req_i (ask[0] != got[0]),
        .xdma_req_i    (ask[1] != got[1]),
        .hold_req_i    (ask[2] != got[2]),
        .dma_req_i     (dma_req),
        .dma_int_i     (dma_int),
        .dtc_req_i     (ask[3] != got[3]),
        .cpu_req_i     (ask[4] != got[4]),
        .gnt_o         (gnt),
        .cyc_type_o    (cyc_type),
        .dma_cyc_o     (dma_cyc),
        .dma_ch_o      (dma_ch),
        .dma_int_o     (dma_in)
    );

    function automatic logic [7:0] mk(int ty, int dc, int ch, int in);
        return {3'(ty), 2'(dc), 2'(ch), 1'(in)};
    endfunction

    task automatic check(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] r, input string t);
        exp_q.push_back(r);
        tag_q.push_back(t);
    endtask

    task automatic drain(input string t);
        int k = 0;
        while (exp_q.size() != 0 && k < 60) begin
            @(negedge clk);
            k++;
        end
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, t, exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
    endtask

    // monitor: pending tracking at posedge, record compare at negedge
    always @(clk) begin
        if (clk) begin
            if (rst_n) bench_pend = bench_pend | dma_req;
        end else if (mon_on) begin
            logic [7:0] r;
            r = {cyc_type, dma_cyc, dma_ch, dma_in};
            if (gnt[4] || gnt[5])
                check((bench_pend == 0) && (dma_cyc == 0), "R6 DTC/CPU granted while DMA busy",
                      {bench_pend, dma_cyc}, 0);
            if (prev_rec[7:5] == 3'd4)
                check(cyc_type == 3'd5 && dma_ch == prev_rec[2:1], "R4 read not followed by its write",
                      r, mk(5, 2, prev_rec[2:1], 0));
            if (prev_rec[4:3] == 2'd2)
                check(dma_cyc != 2'd1, "R5 read right after write", dma_cyc, 0);
            if (dma_cyc == 2'd1) bench_pend[dma_ch] = 1'b0;
            if (r != 0) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "unexpected bus record", r, 0);
                end else begin
                    logic [7:0] e;
                    string      t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(r == e, t, r, e);
                end
            end
            for (int i = 0; i < 5; i++) begin
                if (gnt[GBIT[i]]) got[i]++;
            end
            prev_rec = r;
        end
    end

    task automatic burst_with_refresh();
        int seen  = 0;
        int since = -1;
        int lat   = -1;
        int k     = 0;
        push(mk(4, 1, 0, 0), "R7 burst read 1");
        push(mk(5, 2, 0, 0), "R4 burst write 1");
        push(mk(4, 1, 0, 0), "R7 burst read 2");
        push(mk(5, 2, 0, 0), "R4 burst write 2 before refresh");
        push(mk(1, 0, 0, 0), "R5 refresh in release slot");
        push(mk(4, 1, 0, 0), "R7 burst read 3");
        push(mk(5, 2, 0, 0), "R4 burst write 3");
        push(mk(4, 1, 0, 0), "R7 burst read 4");
        push(mk(5, 2, 0, 0), "R4 burst write 4");
        @(negedge clk);
        dma_req = 3'b001;
        while (seen < 4 && k < 100) begin
            @(negedge clk);
            k++;
            dma_req = '0;
            if (since >= 0 && lat < 0) begin
                since++;
                if (gnt[0]) lat = since;
            end
            if (dma_cyc == 2'd1 && dma_ch == 2'd0) begin
                seen++;
                if (seen < 4) dma_req = 3'b001;
                if (seen == 2) begin
                    ask[0]++;
                    since = 0;
                end
            end
        end
        drain("R5 burst with refresh drained");
        check(lat == 2, "R5 refresh latency from read cycle", lat, 2);
    endtask

    initial begin
        rst_n   = 1'b0;
        dma_req = '0;
        dma_int = '0;
        repeat (3) @(negedge clk);
        check(gnt == 0, "R1 grants in reset", gnt, 0);
        check(cyc_type == 0, "R1 cycle type in reset", cyc_type, 0);
        check(dma_cyc == 0, "R1 DMA phase in reset", dma_cyc, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(gnt == 0 && cyc_type == 0 && dma_cyc == 0, "R1 idle after reset",
              {gnt, cyc_type, dma_cyc}, 0);
        mon_on = 1'b1;

        // all non-DMA requesters at once: R2 R3
        push(mk(1, 0, 0, 0), "R3 refresh first");
        push(mk(2, 0, 0, 0), "R3 ext engine second");
        push(mk(3, 0, 0, 0), "R3 hold third");
        push(mk(6, 0, 0, 0), "R3 DTC before CPU");
        push(mk(7, 0, 0, 0), "R3 CPU last");
        @(negedge clk);
        for (int i = 0; i < 5; i++) ask[i]++;
        drain("R2 one grant per request");

        // urgent requesters hold back an external DMA: R10
        push(mk(1, 0, 0, 0), "R10 refresh before DMA");
        push(mk(2, 0, 0, 0), "R10 ext engine before DMA");
        push(mk(3, 0, 0, 0), "R10 hold before DMA");
        push(mk(4, 1, 0, 0), "R10 DMA read after urgent ones");
        push(mk(5, 2, 0, 0), "R4 DMA write");
        @(negedge clk);
        ask[0]++; ask[1]++; ask[2]++;
        dma_req = 3'b001;
        @(negedge clk);
        dma_req = '0;
        drain("R10 drained");

        // three channels at once: R7
        push(mk(4, 1, 0, 0), "R7 channel 0 first");
        push(mk(5, 2, 0, 0), "R7 channel 0 write");
        push(mk(4, 1, 1, 0), "R7 channel 1 second");
        push(mk(5, 2, 1, 0), "R7 channel 1 write");
        push(mk(4, 1, 2, 0), "R7 channel 2 third");
        push(mk(5, 2, 2, 0), "R7 channel 2 write");
        @(negedge clk);
        dma_req = 3'b111;
        @(negedge clk);
        dma_req = '0;
        drain("R7 multi-channel drained");

        // held request served after a running transfer: R7
        push(mk(4, 1, 2, 0), "R7 lone channel 2");
        push(mk(5, 2, 2, 0), "R7 lone channel 2 write");
        push(mk(4, 1, 0, 0), "R7 held channel 0 later");
        push(mk(5, 2, 0, 0), "R7 held channel 0 write");
        @(negedge clk);
        dma_req = 3'b100;
        @(negedge clk);
        dma_req = 3'b001;
        @(negedge clk);
        dma_req = '0;
        drain("R7 held request drained");

        // DTC/CPU wait for DMA: R6
        push(mk(4, 1, 1, 0), "R6 DMA read ahead of DTC/CPU");
        push(mk(5, 2, 1, 0), "R6 DMA write ahead of DTC/CPU");
        push(mk(6, 0, 0, 0), "R6 DTC after DMA");
        push(mk(7, 0, 0, 0), "R6 CPU after DTC");
        @(negedge clk);
        dma_req = 3'b010;
        ask[3]++; ask[4]++;
        @(negedge clk);
        dma_req = '0;
        drain("R6 drained");

        // CPU waits behind a DMA that is itself suspended: R6 R10
        push(mk(1, 0, 0, 0), "R10 refresh suspends DMA");
        push(mk(4, 1, 0, 0), "R6 DMA read before CPU");
        push(mk(5, 2, 0, 0), "R6 DMA write before CPU");
        push(mk(7, 0, 0, 0), "R6 CPU after suspended DMA");
        @(negedge clk);
        ask[0]++; ask[4]++;
        dma_req = 3'b001;
        @(negedge clk);
        dma_req = '0;
        drain("R6 suspended case drained");

        burst_with_refresh();

        // internal-space channel overlaps urgent cycles: R8 R9
        push(mk(1, 1, 2, 1), "R8 R9 refresh with internal read");
        push(mk(2, 2, 2, 1), "R8 R9 ext engine with internal write");
        @(negedge clk);
        dma_int = 3'b100;
        dma_req = 3'b100;
        ask[0]++; ask[1]++;
        @(negedge clk);
        dma_req = '0;
        drain("R8 internal overlap drained");
        dma_int = '0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule